// File: doc/BRIEF.md
# Fractional Baud Prescaler with Keyed Indexed Registers

This block is the clock front end of an enhanced 16550-compatible UART. Software reaches two extra byte registers, a clock prescaler and an additional control register, through an indirect path: an index goes into the scratch location and the data goes through the indexed control location. Those indirect writes only land once an enhanced-mode bit is set. That bit lives in a feature register that is visible only while the line control register holds a configuration key.

The prescaler value is a ratio in eighths of the input clock. A value of 9 divides by 1.125, and a value of 16 divides by 2. A phase accumulator turns the ratio into a stream of single-cycle enable pulses, `baud_en`, which drives a conventional 16x divisor counter outside this block. The prescaler acts only while the clock-select bit of the modem control register is set. The block also reports the transmit and receive FIFO depths through two read-only bytes, and it sends bit 4 of the additional control register to the transceiver logic as an automatic-DTR enable.

Top module: `frac_baud_prescaler`

## Requirements
- R1: During reset `baud_en` is low. After reset the line control (offset 3), modem control (offset 4), feature (offset 2) and indexed-data (offset 5) reads all return 0x00.
- R2: The feature register at offset 2 can be written and read back only while the line control register holds 0xBF. At any other line control value, a read of offset 2 returns 0x00 and the stored value is kept.
- R3: A write to offset 2 while line control is not 0xBF raises `fcr_wstb` during that write cycle and leaves the feature register unchanged. While the key is present, `fcr_wstb` stays low.
- R4: Indexed access works as follows: the index is written to offset 7, which reads back as written. Offset 5 then reads and writes the indexed register, where index 0x01 is the prescaler and index 0x00 is the additional control register. A write to any other index is dropped, and a read of any other index returns 0x00.
- R5: An indexed write takes effect only while bit 4 of the feature register is 1. When that bit is 0, the indexed registers keep their values.
- R6: While modem control bit 7 (clock select) is 0, `baud_en` is high on every cycle.
- R7: While clock select is 1 and the prescaler value P is 8 or more, every window of P consecutive cycles holds exactly 8 `baud_en` pulses.
- R8: A prescaler value below 8 acts as a ratio of 1.0, so `baud_en` is high on every cycle.
- R9: `auto_dtr_en` equals bit 4 of the additional control register. It changes only through an indexed write.
- R10: Offset 0x0C reads the transmit FIFO depth and offset 0x0D reads the receive FIFO depth. Both are set by parameters, and writes to these offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the clock being prescaled |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, sampled at the rising edge |
| addr | input | ADDR_W | Register offset for both read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| fcr_wstb | output | 1 | A write to offset 2 without the key, passed to the neighbouring FIFO control register |
| baud_en | output | 1 | Prescaled clock-enable pulse stream |
| auto_dtr_en | output | 1 | Automatic-DTR enable for the transceiver logic |

## Verification
All register writes land at the rising edge that samples `wr_en`. Reads are combinational, so the bench drives on the falling edge and reads back on the next falling edge, half a cycle after the write. `fcr_wstb` is combinational and is sampled 1 ns after it is driven, inside the same cycle. `baud_en` sits one register behind the accumulator, and a prescaler or modem control write restarts the accumulator. The bench therefore lets two cycles pass after such a write before it counts pulses. Counts are taken over windows that are whole multiples of P, where the exact result of 8 pulses per P cycles holds whatever the starting phase.

// File: rtl/pfx_pkg.sv
`timescale 1ns/1ps
package pfx_pkg;
  localparam int BYTE_W = 8;
  localparam int ACC_W = BYTE_W + 1;
  localparam int STEP = 8;
  localparam logic [BYTE_W-1:0] CFG_KEY = 8'hBF;
  localparam int IDX_ACR = 0;
  localparam int IDX_CPR = 1;
  localparam int NUM_IDX = 2;
  localparam int OFS_EFR = 2;
  localparam int OFS_LCR = 3;
  localparam int OFS_MCR = 4;
  localparam int OFS_ICR = 5;
  localparam int OFS_SPR = 7;
  localparam int OFS_TFS = 12;
  localparam int OFS_RFS = 13;
  localparam int ENH_BIT = 4;
  localparam int DTR_BIT = 4;
  localparam int CLKSEL_BIT = 7;

  typedef struct packed {
    logic lcr;
    logic mcr;
    logic spr;
    logic icr;
    logic efr;
    logic fcr;
  } wr_dec_t;

  // effective divisor in eighths; small values clamp to unity
  function automatic logic [ACC_W-1:0] eff_div(input logic [BYTE_W-1:0] raw);
    if (raw < BYTE_W'(STEP)) return ACC_W'(STEP);
    return ACC_W'(raw);
  endfunction

  function automatic logic [ACC_W-1:0] acc_sum(input logic [ACC_W-1:0] acc);
    return acc + ACC_W'(STEP);
  endfunction
endpackage

// File: rtl/pfx_decode.sv
`timescale 1ns/1ps
module pfx_decode
  import pfx_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] lcr_q,
  output wr_dec_t           dec,
  output logic              key_on
);
  logic at_efr;

  always_comb begin
    key_on  = (lcr_q == CFG_KEY);
    at_efr  = wr_en && (addr == ADDR_W'(OFS_EFR));
    dec.lcr = wr_en && (addr == ADDR_W'(OFS_LCR));
    dec.mcr = wr_en && (addr == ADDR_W'(OFS_MCR));
    dec.spr = wr_en && (addr == ADDR_W'(OFS_SPR));
    dec.icr = wr_en && (addr == ADDR_W'(OFS_ICR));
    dec.efr = at_efr && key_on;
    dec.fcr = at_efr && !key_on;
  end
endmodule

// File: rtl/pfx_regbank.sv
`timescale 1ns/1ps
module pfx_regbank
  import pfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wr_dec_t           dec,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lcr_q,
  output logic [BYTE_W-1:0] mcr_q,
  output logic [BYTE_W-1:0] spr_q,
  output logic [BYTE_W-1:0] efr_q,
  output logic [BYTE_W-1:0] cpr_q,
  output logic [BYTE_W-1:0] icr_rd,
  output logic              cpr_we,
  output logic              dtr_bit
);
  logic [BYTE_W-1:0] ix_q [NUM_IDX];
  logic              enh;

  assign enh    = efr_q[ENH_BIT];
  assign cpr_we = dec.icr && enh && (spr_q == BYTE_W'(IDX_CPR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr_q <= '0;
      mcr_q <= '0;
      spr_q <= '0;
      efr_q <= '0;
    end else begin
      if (dec.lcr) lcr_q <= wdata;
      if (dec.mcr) mcr_q <= wdata;
      if (dec.spr) spr_q <= wdata;
      if (dec.efr) efr_q <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_IDX; g++) begin : g_ix
    always_ff @(posedge clk) begin
      if (!rst_n) ix_q[g] <= '0;
      else if (dec.icr && enh && (spr_q == BYTE_W'(g))) ix_q[g] <= wdata;
    end
  end

  always_comb begin
    icr_rd = '0;
    for (int k = 0; k < NUM_IDX; k++)
      if (spr_q == BYTE_W'(k)) icr_rd = ix_q[k];
  end

  assign cpr_q   = ix_q[IDX_CPR];
  assign dtr_bit = ix_q[IDX_ACR][DTR_BIT];
endmodule

// File: rtl/pfx_frac_gen.sv
`timescale 1ns/1ps
module pfx_frac_gen
  import pfx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clksel,
  input  logic [BYTE_W-1:0] cpr,
  input  logic              restart,
  output logic              baud_en,
  output logic [ACC_W-1:0]  acc_q
);
  logic [ACC_W-1:0] div;
  logic [ACC_W-1:0] sum;
  logic             hit;

  always_comb begin
    div = eff_div(cpr);
    sum = acc_sum(acc_q);
    hit = (sum >= div);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      baud_en <= 1'b0;
    end else if (restart || !clksel) begin
      acc_q   <= '0;
      baud_en <= !clksel;
    end else if (hit) begin
      acc_q   <= sum - div;
      baud_en <= 1'b1;
    end else begin
      acc_q   <= sum;
      baud_en <= 1'b0;
    end
  end
endmodule

// File: rtl/pfx_rd_mux.sv
`timescale 1ns/1ps
module pfx_rd_mux
  import pfx_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [BYTE_W-1:0] TFS_VAL = 8'd128,
  parameter logic [BYTE_W-1:0] RFS_VAL = 8'd128
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              key_on,
  input  logic [BYTE_W-1:0] lcr_q,
  input  logic [BYTE_W-1:0] mcr_q,
  input  logic [BYTE_W-1:0] spr_q,
  input  logic [BYTE_W-1:0] efr_q,
  input  logic [BYTE_W-1:0] icr_rd,
  output logic [BYTE_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_EFR))      rdata = key_on ? efr_q : '0;
    else if (addr == ADDR_W'(OFS_LCR)) rdata = lcr_q;
    else if (addr == ADDR_W'(OFS_MCR)) rdata = mcr_q;
    else if (addr == ADDR_W'(OFS_ICR)) rdata = icr_rd;
    else if (addr == ADDR_W'(OFS_SPR)) rdata = spr_q;
    else if (addr == ADDR_W'(OFS_TFS)) rdata = TFS_VAL;
    else if (addr == ADDR_W'(OFS_RFS)) rdata = RFS_VAL;
  end
endmodule

// File: rtl/frac_baud_prescaler.sv
`timescale 1ns/1ps
module frac_baud_prescaler
  import pfx_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int TX_FIFO_DEPTH = 128,
  parameter int RX_FIFO_DEPTH = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              fcr_wstb,
  output logic              baud_en,
  output logic              auto_dtr_en
);
  localparam logic [BYTE_W-1:0] TFS_VAL = BYTE_W'(TX_FIFO_DEPTH);
  localparam logic [BYTE_W-1:0] RFS_VAL = BYTE_W'(RX_FIFO_DEPTH);

  wr_dec_t           dec;
  logic              key_on;
  logic [BYTE_W-1:0] lcr_q, mcr_q, spr_q, efr_q, cpr_q, icr_rd;
  logic              cpr_we;
  logic              clksel;
  logic              restart;
  logic [ACC_W-1:0]  acc_q;

  pfx_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en(wr_en), .addr(addr), .lcr_q(lcr_q), .dec(dec), .key_on(key_on)
  );

  pfx_regbank u_regs (
    .clk(clk), .rst_n(rst_n), .dec(dec), .wdata(wdata),
    .lcr_q(lcr_q), .mcr_q(mcr_q), .spr_q(spr_q), .efr_q(efr_q),
    .cpr_q(cpr_q), .icr_rd(icr_rd), .cpr_we(cpr_we), .dtr_bit(auto_dtr_en)
  );

  assign clksel   = mcr_q[CLKSEL_BIT];
  assign restart  = cpr_we || dec.mcr;
  assign fcr_wstb = dec.fcr;

  pfx_frac_gen u_gen (
    .clk(clk), .rst_n(rst_n), .clksel(clksel), .cpr(cpr_q),
    .restart(restart), .baud_en(baud_en), .acc_q(acc_q)
  );

  pfx_rd_mux #(.ADDR_W(ADDR_W), .TFS_VAL(TFS_VAL), .RFS_VAL(RFS_VAL)) u_rd (
    .addr(addr), .key_on(key_on), .lcr_q(lcr_q), .mcr_q(mcr_q),
    .spr_q(spr_q), .efr_q(efr_q), .icr_rd(icr_rd), .rdata(rdata)
  );
endmodule

// File: rtl/frac_baud_prescaler_chk.sv
`timescale 1ns/1ps
module frac_baud_prescaler_chk
  import pfx_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] lcr_q,
  input logic [BYTE_W-1:0] efr_q,
  input logic [BYTE_W-1:0] cpr_q,
  input logic              clksel,
  input logic [ACC_W-1:0]  acc_q,
  input logic              baud_en,
  input logic              auto_dtr_en
);
  // R2
  efr_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_q != CFG_KEY) |=> $stable(efr_q));

  // R3
  efr_nokey_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_EFR) && lcr_q != CFG_KEY) |=> $stable(efr_q));

  // R5
  cpr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !efr_q[ENH_BIT] |=> $stable(cpr_q));

  // R6
  clksel_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clksel |=> baud_en);

  // R7
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < eff_div(cpr_q));

  // R9
  dtr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_W'(OFS_ICR)) |=> $stable(auto_dtr_en));
endmodule

bind frac_baud_prescaler frac_baud_prescaler_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .lcr_q(lcr_q),
  .efr_q(efr_q), .cpr_q(cpr_q), .clksel(clksel), .acc_q(acc_q),
  .baud_en(baud_en), .auto_dtr_en(auto_dtr_en)
);

// File: tb/sim_frac_baud_prescaler.sv
`timescale 1ns/1ps
module sim_frac_baud_prescaler;
  localparam int TXD = 64;
  localparam int RXD = 48;
  localparam int NV = 40;
  localparam int MAX_CYC = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       fcr_wstb, baud_en, auto_dtr_en;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  frac_baud_prescaler #(.ADDR_W(4), .TX_FIFO_DEPTH(TXD), .RX_FIFO_DEPTH(RXD)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .fcr_wstb(fcr_wstb), .baud_en(baud_en), .auto_dtr_en(auto_dtr_en)
  );

  // {write, addr, data, expected, requirement}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 4'h3, 8'h00, 8'h00, 4'd1},   // R1 line control
    {1'b0, 4'h4, 8'h00, 8'h00, 4'd1},   // R1 modem control
    {1'b0, 4'h2, 8'h00, 8'h00, 4'd1},   // R1 feature hidden
    {1'b0, 4'h5, 8'h00, 8'h00, 4'd1},   // R1 indexed data
    {1'b0, 4'hC, 8'h00, 8'd64, 4'd10},  // R10 tx depth
    {1'b0, 4'hD, 8'h00, 8'd48, 4'd10},  // R10 rx depth
    {1'b1, 4'hC, 8'hFF, 8'h00, 4'd10},
    {1'b0, 4'hC, 8'h00, 8'd64, 4'd10},  // R10 write ignored
    {1'b1, 4'hD, 8'h00, 8'h00, 4'd10},
    {1'b0, 4'hD, 8'h00, 8'd48, 4'd10},
    {1'b1, 4'h7, 8'h01, 8'h00, 4'd5},
    {1'b1, 4'h5, 8'h20, 8'h00, 4'd5},
    {1'b0, 4'h5, 8'h00, 8'h00, 4'd5},   // R5 locked before enhanced mode
    {1'b0, 4'h7, 8'h00, 8'h01, 4'd4},   // R4 index readback
    {1'b1, 4'h2, 8'h55, 8'h00, 4'd3},
    {1'b1, 4'h3, 8'hBF, 8'h00, 4'd2},
    {1'b0, 4'h2, 8'h00, 8'h00, 4'd3},   // R3 unkeyed write did not land
    {1'b1, 4'h2, 8'h10, 8'h00, 4'd2},
    {1'b0, 4'h2, 8'h00, 8'h10, 4'd2},   // R2 keyed readback
    {1'b1, 4'h3, 8'h03, 8'h00, 4'd2},
    {1'b0, 4'h2, 8'h00, 8'h00, 4'd2},   // R2 paged out
    {1'b0, 4'h3, 8'h00, 8'h03, 4'd2},
    {1'b1, 4'h5, 8'h0C, 8'h00, 4'd4},
    {1'b0, 4'h5, 8'h00, 8'h0C, 4'd4},   // R4 prescaler via index 1
    {1'b1, 4'h7, 8'h00, 8'h00, 4'd4},
    {1'b1, 4'h5, 8'h10, 8'h00, 4'd9},
    {1'b0, 4'h5, 8'h00, 8'h10, 4'd4},   // R4 additional control via index 0
    {1'b1, 4'h7, 8'h05, 8'h00, 4'd4},
    {1'b1, 4'h5, 8'h77, 8'h00, 4'd4},
    {1'b0, 4'h5, 8'h00, 8'h00, 4'd4},   // R4 unknown index reads zero
    {1'b0, 4'h7, 8'h00, 8'h05, 4'd4},
    {1'b1, 4'h3, 8'hBF, 8'h00, 4'd5},
    {1'b1, 4'h2, 8'h00, 8'h00, 4'd5},
    {1'b1, 4'h3, 8'h03, 8'h00, 4'd5},
    {1'b1, 4'h7, 8'h01, 8'h00, 4'd5},
    {1'b1, 4'h5, 8'h40, 8'h00, 4'd5},
    {1'b0, 4'h5, 8'h00, 8'h0C, 4'd5},   // R5 enhanced bit cleared, kept
    {1'b1, 4'h3, 8'hBF, 8'h00, 4'd5},
    {1'b1, 4'h2, 8'h10, 8'h00, 4'd5},
    {1'b1, 4'h3, 8'h03, 8'h00, 4'd5}
  };

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_pulses(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (baud_en) c++;
    end
  endtask

  task automatic ratio_case(input logic [7:0] p, input int win, input int exp, input string tag);
    int c;
    wr(4'h5, p);
    repeat (2) @(negedge clk);
    count_pulses(win, c);
    check($sformatf("%s P=%0d window=%0d", tag, p, win), c, exp);
  endtask

  initial begin
    #(MAX_CYC * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 baud_en low in reset", baud_en, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) wr(VEC[i][23:20], VEC[i][19:12]);
      else begin
        @(negedge clk);
        addr = VEC[i][23:20]; wr_en = 1'b0;
        #1;
        check($sformatf("R%0d vector %0d", VEC[i][3:0], i), rdata, VEC[i][11:4]);
      end
    end

    // R3 strobe only without the key
    @(negedge clk);
    addr = 4'h2; wdata = 8'h00; wr_en = 1'b1;
    #1 check("R3 strobe without key", fcr_wstb, 1);
    @(negedge clk);
    wr_en = 1'b0;
    wr(4'h3, 8'hBF);
    @(negedge clk);
    addr = 4'h2; wdata = 8'h10; wr_en = 1'b1;
    #1 check("R3 no strobe with key", fcr_wstb, 0);
    @(negedge clk);
    wr_en = 1'b0;
    wr(4'h3, 8'h03);

    // R9 automatic-DTR output
    wr(4'h7, 8'h00);
    wr(4'h5, 8'h10);
    check("R9 dtr set", auto_dtr_en, 1);
    wr(4'h5, 8'h00);
    check("R9 dtr clear", auto_dtr_en, 0);

    // R6 clock select off
    count_pulses(20, c);
    check("R6 bypass every cycle", c, 20);

    wr(4'h7, 8'h01);
    wr(4'h5, 8'h09);
    wr(4'h4, 8'h80);
    repeat (2) @(negedge clk);
    count_pulses(9, c);
    check("R7 P=9 window=9", c, 8);
    count_pulses(18, c);
    check("R7 P=9 window=18", c, 16);
    ratio_case(8'd13, 13, 8, "R7");
    ratio_case(8'd20, 40, 16, "R7");
    ratio_case(8'd255, 255, 8, "R7");
    ratio_case(8'd8, 12, 12, "R8");
    ratio_case(8'd3, 10, 10, "R8");
    ratio_case(8'd0, 10, 10, "R8");

    wr(4'h5, 8'd20);
    wr(4'h4, 8'h00);
    repeat (2) @(negedge clk);
    count_pulses(15, c);
    check("R6 bypass with prescaler loaded", c, 15);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule